// File: doc/BRIEF.md
# Status Flags Register with Branch and Skip Resolver

This block keeps the 8-bit processor status word and resolves control flow in the same cycle as the instruction that needs it. Each cycle it takes the flag results of the arithmetic unit together with a per-bit write mask. It also takes one command: set a flag, clear a flag, copy a register bit into the transfer flag, copy the transfer flag into a register bit, branch on a flag, branch on the signed comparison result, or skip on a register bit. A command that writes the status word takes effect at the next clock edge. Branch and skip decisions are combinational and use the status word as it stands now.

Relative branches carry a short two's complement offset. The resolver widens that offset to the program counter width, adds it and adds one more. A skip that holds jumps over the following instruction. That means two addresses when the following instruction is one word long, and three when it is two words long. Every other case moves on to the next address. The status word is laid out from the top bit down as interrupt enable (7), transfer (6), half carry (5), sign (4), overflow (3), negative (2), zero (1) and carry (0).

The command decoder is written as an enumerated command set with a unique case. The commands are IDLE (0), FSET (1), FCLR (2), BSTORE (3), BLOAD (4), BRSET (5), BRCLR (6), BRGE (7), BRLT (8), SKSET (9) and SKCLR (10). The status word has two transitions. It either holds each bit, or it takes the new value of a bit that the mask or the command selects.

Top module: `flag_branch_unit`

## Requirements
- R1: While reset is asserted and right after it is released, the status word reads 8'h00.
- R2: With command IDLE (0), at the next edge each status bit whose mask bit is 1 takes the matching arithmetic flag, and each bit whose mask bit is 0 keeps its value.
- R3: Command FSET (1) writes 1 and command FCLR (2) writes 0 into the status bit picked by the 3-bit index, at the next edge. All other bits follow R2.
- R4: When the mask also selects the commanded bit in the same cycle, the value from FSET, FCLR or BSTORE wins over the arithmetic flag.
- R5: Command BSTORE (3) copies bit `bit_sel` of the register operand into the transfer flag (bit 6) at the next edge.
- R6: The register result output always equals the register operand with bit `bit_sel` replaced by the present transfer flag (bit 6). This is the value for command BLOAD (4), and BLOAD leaves the status word to R2 alone.
- R7: BRSET (5) is taken when the indexed status bit is 1, and BRCLR (6) when it is 0. When taken, the next PC is PC + sign-extended 7-bit offset + 1, modulo 2^PC_W.
- R8: BRGE (7) is taken when negative (bit 2) XOR overflow (bit 3) is 0. BRLT (8) is taken when it is 1. The target is the same as in R7.
- R9: When a branch or skip is not taken, and for every other command (codes 0 to 4 and 11 to 15), `taken` is 0 and the next PC is PC + 1 modulo 2^PC_W.
- R10: SKSET (9) holds when bit `bit_sel` of the register operand is 1, and SKCLR (10) holds when it is 0. When the skip holds, `taken` is 1 and the next PC is PC + 2, or PC + 3 when `next_two_word` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alu_flags | input | 8 | New flag values from the arithmetic unit |
| alu_mask | input | 8 | Per-bit write enable for alu_flags |
| cmd | input | 4 | Command code (see requirements) |
| bit_sel | input | 3 | Bit index for status or register bit commands |
| reg_val | input | 8 | Register operand for bit store, bit load and skip |
| offset | input | 7 | Branch displacement, two's complement |
| pc | input | PC_W | Address of the current instruction |
| next_two_word | input | 1 | Following instruction is two words long |
| sreg | output | 8 | Current status word |
| pc_next | output | PC_W | Address of the next instruction |
| taken | output | 1 | Branch or skip taken |
| reg_result | output | 8 | Register operand with the transfer flag inserted |

## Verification
The bench builds the block with PC_W = 8. With that width, address wrap-around in both directions happens at values that are easy to reach, and every offset can be tried at addresses near both ends of the range. The small width allows a full sweep over all 256 status words, where every flag branch is tried at every bit index and both signed comparisons are evaluated. The mask behaviour, the command-over-mask priority, and the skip lengths are each swept over every bit index and over both instruction lengths.

// File: rtl/fbu_pkg.sv
package fbu_pkg;

    localparam int SR_W  = 8;
    localparam int IDX_W = $clog2(SR_W);

    localparam int POS_C = 0;
    localparam int POS_Z = 1;
    localparam int POS_N = 2;
    localparam int POS_V = 3;
    localparam int POS_S = 4;
    localparam int POS_H = 5;
    localparam int POS_T = 6;
    localparam int POS_I = 7;

    typedef enum logic [3:0] {
        CMD_IDLE   = 4'd0,
        CMD_FSET   = 4'd1,
        CMD_FCLR   = 4'd2,
        CMD_BSTORE = 4'd3,
        CMD_BLOAD  = 4'd4,
        CMD_BRSET  = 4'd5,
        CMD_BRCLR  = 4'd6,
        CMD_BRGE   = 4'd7,
        CMD_BRLT   = 4'd8,
        CMD_SKSET  = 4'd9,
        CMD_SKCLR  = 4'd10
    } cmd_e;

    typedef enum logic [1:0] {
        FLOW_SEQ    = 2'd0,
        FLOW_BRANCH = 2'd1,
        FLOW_SKIP   = 2'd2
    } flow_e;

endpackage

// File: rtl/fbu_status_store.sv
module fbu_status_store
    import fbu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  cmd_e             cmd,
    input  logic [IDX_W-1:0] bit_sel,
    input  logic [SR_W-1:0]  alu_flags,
    input  logic [SR_W-1:0]  alu_mask,
    input  logic             store_bit,
    output logic [SR_W-1:0]  sreg
);

    logic [SR_W-1:0] sreg_d;

    // Next-state process: masked merge first, then the command overrides.
    always_comb begin
        sreg_d = (sreg & ~alu_mask) | (alu_flags & alu_mask);
        unique case (cmd)
            CMD_FSET:   sreg_d[bit_sel] = 1'b1;
            CMD_FCLR:   sreg_d[bit_sel] = 1'b0;
            CMD_BSTORE: sreg_d[POS_T]   = store_bit;
            default:    ;
        endcase
    end

    // State register process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg <= '0;
        end else begin
            sreg <= sreg_d;
        end
    end

    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_FSET) |=> sreg[$past(bit_sel)] == 1'b1);

    p_clr_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_FCLR) |=> sreg[$past(bit_sel)] == 1'b0);

    p_store_t_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_BSTORE) |=> sreg[POS_T] == $past(store_bit));

endmodule

// File: rtl/fbu_cond_eval.sv
module fbu_cond_eval
    import fbu_pkg::*;
(
    input  cmd_e             cmd,
    input  logic [SR_W-1:0]  sreg,
    input  logic [SR_W-1:0]  reg_val,
    input  logic [IDX_W-1:0] bit_sel,
    output flow_e            flow,
    output logic             cond
);

    logic sel_flag;
    logic sel_reg;
    logic signed_lt;

    assign sel_flag  = sreg[bit_sel];
    assign sel_reg   = reg_val[bit_sel];
    assign signed_lt = sreg[POS_N] ^ sreg[POS_V];

    always_comb begin
        flow = FLOW_SEQ;
        cond = 1'b0;
        unique case (cmd)
            CMD_BRSET: begin flow = FLOW_BRANCH; cond = sel_flag;   end
            CMD_BRCLR: begin flow = FLOW_BRANCH; cond = ~sel_flag;  end
            CMD_BRGE:  begin flow = FLOW_BRANCH; cond = ~signed_lt; end
            CMD_BRLT:  begin flow = FLOW_BRANCH; cond = signed_lt;  end
            CMD_SKSET: begin flow = FLOW_SKIP;   cond = sel_reg;    end
            CMD_SKCLR: begin flow = FLOW_SKIP;   cond = ~sel_reg;   end
            default:   begin flow = FLOW_SEQ;    cond = 1'b0;       end
        endcase
    end

endmodule

// File: rtl/fbu_pc_resolve.sv
module fbu_pc_resolve
    import fbu_pkg::*;
#(
    parameter int PC_W  = 12,
    parameter int OFF_W = 7
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [OFF_W-1:0] offset,
    input  flow_e            flow,
    input  logic             cond,
    input  logic             two_word,
    output logic [PC_W-1:0]  pc_next,
    output logic             taken
);

    localparam int EXT_W = PC_W - OFF_W;

    logic [PC_W-1:0] off_ext;
    logic [PC_W-1:0] skip_step;

    assign off_ext   = {{EXT_W{offset[OFF_W-1]}}, offset};
    assign skip_step = two_word ? PC_W'(3) : PC_W'(2);

    always_comb begin
        taken   = 1'b0;
        pc_next = pc + PC_W'(1);
        unique case (flow)
            FLOW_BRANCH: begin
                taken = cond;
                if (cond) pc_next = pc + off_ext + PC_W'(1);
            end
            FLOW_SKIP: begin
                taken = cond;
                if (cond) pc_next = pc + skip_step;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/flag_branch_unit.sv
module flag_branch_unit
    import fbu_pkg::*;
#(
    parameter int PC_W  = 12,
    parameter int OFF_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SR_W-1:0]   alu_flags,
    input  logic [SR_W-1:0]   alu_mask,
    input  logic [3:0]        cmd,
    input  logic [IDX_W-1:0]  bit_sel,
    input  logic [SR_W-1:0]   reg_val,
    input  logic [OFF_W-1:0]  offset,
    input  logic [PC_W-1:0]   pc,
    input  logic              next_two_word,
    output logic [SR_W-1:0]   sreg,
    output logic [PC_W-1:0]   pc_next,
    output logic              taken,
    output logic [SR_W-1:0]   reg_result
);

    cmd_e  cmd_q;
    flow_e flow;
    logic  cond;

    assign cmd_q = cmd_e'(cmd);

    fbu_status_store i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd_q),
        .bit_sel   (bit_sel),
        .alu_flags (alu_flags),
        .alu_mask  (alu_mask),
        .store_bit (reg_val[bit_sel]),
        .sreg      (sreg)
    );

    fbu_cond_eval i_cond (
        .cmd     (cmd_q),
        .sreg    (sreg),
        .reg_val (reg_val),
        .bit_sel (bit_sel),
        .flow    (flow),
        .cond    (cond)
    );

    fbu_pc_resolve #(.PC_W(PC_W), .OFF_W(OFF_W)) i_pc (
        .pc       (pc),
        .offset   (offset),
        .flow     (flow),
        .cond     (cond),
        .two_word (next_two_word),
        .pc_next  (pc_next),
        .taken    (taken)
    );

    always_comb begin
        reg_result          = reg_val;
        reg_result[bit_sel] = sreg[POS_T];
    end

    p_idle_merge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'd0) |=> sreg == (($past(sreg) & ~$past(alu_mask)) |
                                   ($past(alu_flags) & $past(alu_mask))));

    p_seq_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !taken |-> pc_next == pc + PC_W'(1));

    p_skip_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && (cmd == 4'd9 || cmd == 4'd10)) |->
            pc_next == pc + (next_two_word ? PC_W'(3) : PC_W'(2)));

    p_seq_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd < 4'd5 || cmd > 4'd10) |-> !taken);

endmodule

// File: tb/test_flag_branch_unit.sv
`timescale 1ns/1ps
module test_flag_branch_unit;

    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    alu_flags = '0;
    logic [7:0]    alu_mask = '0;
    logic [3:0]    cmd = '0;
    logic [2:0]    bit_sel = '0;
    logic [7:0]    reg_val = '0;
    logic [6:0]    offset = '0;
    logic [PW-1:0] pc = '0;
    logic          next_two_word = 1'b0;
    logic [7:0]    sreg;
    logic [PW-1:0] pc_next;
    logic          taken;
    logic [7:0]    reg_result;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    flag_branch_unit #(.PC_W(PW), .OFF_W(7)) i_flag_branch_unit (
        .clk(clk), .rst_n(rst_n), .alu_flags(alu_flags), .alu_mask(alu_mask),
        .cmd(cmd), .bit_sel(bit_sel), .reg_val(reg_val), .offset(offset),
        .pc(pc), .next_two_word(next_two_word), .sreg(sreg),
        .pc_next(pc_next), .taken(taken), .reg_result(reg_result)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive at the falling edge, let one rising edge pass, sample at the next falling edge.
    task automatic step(input logic [3:0] c, input logic [2:0] b,
                        input logic [7:0] f, input logic [7:0] m, input logic [7:0] r);
        @(negedge clk);
        cmd = c; bit_sel = b; alu_flags = f; alu_mask = m; reg_val = r;
        @(negedge clk);
        cmd = 4'd0; alu_mask = 8'h00;
    endtask

    task automatic load(input logic [7:0] v);
        step(4'd0, 3'd0, v, 8'hFF, 8'h00);
    endtask

    function automatic int br_target(input int p, input int k);
        int ks;
        ks = (k >= 64) ? k - 128 : k;
        return (p + ks + 1) & 8'hFF;
    endfunction

    initial begin
        #400000;
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        #7;
        chk("R1 in reset", sreg, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", sreg, 0);

        // R2 masked merge
        for (int m = 0; m < 256; m += 7) begin
            logic [7:0] a, f;
            a = 8'(m * 13 + 5);
            f = 8'(m * 37 + 91);
            load(a);
            chk("R2 load", sreg, a);
            step(4'd0, 3'd0, f, 8'(m), 8'h00);
            chk("R2 merge", sreg, (a & ~8'(m)) | (f & 8'(m)));
        end

        // R3 set and clear, R4 priority over mask
        for (int b = 0; b < 8; b++) begin
            load(8'h00);
            step(4'd1, 3'(b), 8'h00, 8'h00, 8'h00);
            chk("R3 set", sreg, 1 << b);
            load(8'hFF);
            step(4'd2, 3'(b), 8'h00, 8'h00, 8'h00);
            chk("R3 clear", sreg, 8'hFF & ~(1 << b));
            load(8'h00);
            step(4'd1, 3'(b), 8'h00, 8'hFF, 8'h00);
            chk("R4 set over mask", sreg, 1 << b);
            load(8'h00);
            step(4'd2, 3'(b), 8'hFF, 8'hFF, 8'h00);
            chk("R4 clear over mask", sreg, 8'hFF & ~(1 << b));
        end

        // R5 bit store into T, incl. priority over mask on T
        for (int b = 0; b < 8; b++) begin
            load(8'h00);
            step(4'd3, 3'(b), 8'h00, 8'h00, 8'(1 << b));
            chk("R5 store one", sreg, 8'h40);
            load(8'hFF);
            step(4'd3, 3'(b), 8'hFF, 8'hFF, ~8'(1 << b));
            chk("R5/R4 store zero over mask", sreg, 8'hBF);
        end

        // R6 bit load: result and no status change
        for (int t = 0; t < 2; t++) begin
            load(t ? 8'h40 : 8'hBF);
            for (int b = 0; b < 8; b++) begin
                for (int r = 0; r < 256; r += 51) begin
                    int e;
                    @(negedge clk);
                    cmd = 4'd4; bit_sel = 3'(b); reg_val = 8'(r);
                    #1;
                    e = t ? (r | (1 << b)) : (r & ~(1 << b));
                    chk("R6 result", reg_result, e);
                end
            end
            @(negedge clk);
            chk("R6 status kept", sreg, t ? 8'h40 : 8'hBF);
        end

        // R7, R8, R9 over all status words
        for (int s = 0; s < 256; s++) begin
            load(8'(s));
            for (int c = 5; c <= 8; c++) begin
                for (int b = 0; b < 8; b++) begin
                    int k, p, ex_t, ex_pc, lt;
                    k = (s * 5 + b * 19 + c) & 8'h7F;
                    p = (s ^ 8'h5A) & 8'hFF;
                    lt = ((s >> 2) ^ (s >> 3)) & 1;
                    case (c)
                        5: ex_t = (s >> b) & 1;
                        6: ex_t = ((s >> b) & 1) ^ 1;
                        7: ex_t = lt ^ 1;
                        default: ex_t = lt;
                    endcase
                    ex_pc = ex_t ? br_target(p, k) : ((p + 1) & 8'hFF);
                    cmd = 4'(c); bit_sel = 3'(b); offset = 7'(k); pc = 8'(p);
                    #0.5;
                    chk((c < 7) ? "R7 taken" : "R8 taken", taken, ex_t);
                    chk(ex_t ? "R7/R8 target" : "R9 not taken pc", pc_next, ex_pc);
                    #0.5;
                    if (c >= 7) break;
                end
            end
            cmd = 4'd0;
        end

        // R7 full offset sweep with wrap both ways
        load(8'h01);
        for (int k = 0; k < 128; k++) begin
            for (int q = 0; q < 2; q++) begin
                int p;
                p = q ? 8'hF8 : 8'h03;
                cmd = 4'd5; bit_sel = 3'd0; offset = 7'(k); pc = 8'(p);
                #0.5;
                chk("R7 offset sweep", pc_next, br_target(p, k));
                #0.5;
            end
        end

        // R9 non-branch commands
        for (int c = 0; c < 16; c++) begin
            if (c >= 5 && c <= 10) continue;
            @(negedge clk);
            cmd = 4'(c); alu_mask = 8'h00; pc = 8'hFF; reg_val = 8'hFF;
            #0.5;
            chk("R9 seq taken", taken, 0);
            chk("R9 seq wrap", pc_next, 0);
        end

        // R10 skips
        for (int c = 9; c <= 10; c++) begin
            for (int b = 0; b < 8; b++) begin
                for (int r = 0; r < 256; r += 37) begin
                    for (int w = 0; w < 2; w++) begin
                        int h, e_pc;
                        h = (r >> b) & 1;
                        if (c == 10) h ^= 1;
                        e_pc = h ? ((8'hFE + 2 + w) & 8'hFF) : 8'hFF;
                        cmd = 4'(c); bit_sel = 3'(b); reg_val = 8'(r);
                        pc = 8'hFE; next_two_word = 1'(w);
                        #0.5;
                        chk("R10 taken", taken, h);
                        chk("R10 pc", pc_next, e_pc);
                        #0.5;
                    end
                end
            end
        end

        cmd = 4'd0;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule